// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and a single-beat local memory port. Each request names a bus, device, function and register offset, and says whether it is a read or a write. The block checks whether that device can exist on a point-to-point link. If it can, the block programs an outbound translation window with the access type and the target identifier, and then issues one downstream beat to the matching local address.

Bus 0 is the root's own register space, so its accesses go straight to the local register base. Every other bus is reached through the remote window. A request for a device that cannot exist never reaches the downstream port. A downstream abort does not propagate as a fault. In both cases the requester gets an error flag, and a read returns all ones.

Requests are handled one at a time. The window registers change only in the setup cycle that comes before a beat. They never change while a beat is outstanding.

Top module: `cfg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_valid` are 0, `win_type` is 4 and `win_target` is 0.
- R2: A request with bus 0 and device above 1, or with bus 1 and device above 0, is rejected. It produces a response with `rsp_err`=1 and no downstream beat.
- R3: A rejected read returns 0xFFFFFFFF. A rejected write is dropped. In both cases `win_type` and `win_target` keep their previous values.
- R4: During the beat of an accepted request, `win_type` is 4 (type-0 configuration) for buses 0 and 1, and 5 (type-1) for bus 2 and above.
- R5: An accepted bus-0 access uses `mem_addr` = 0x01FFC000 + aligned offset and leaves `win_target` unchanged.
- R6: An accepted access to any bus other than 0 uses `mem_addr` = 0x01F00000 + aligned offset. `win_target` then holds bus in bits [31:24], device in bits [23:19], function in bits [18:16] and zero below.
- R7: The aligned offset is the request offset with bits [1:0] cleared, so `mem_addr[1:0]` is always 0.
- R8: If `mem_abort` is high with `mem_done`, the response has `rsp_err`=1, and a read returns 0xFFFFFFFF.
- R9: A beat that completes without abort gives `rsp_err`=0. A read returns `mem_rdata`. A write drives `mem_write`=1 and `mem_wdata` equal to the request data.
- R10: `req_ready` is 0 from the accepting edge until the response cycle has passed. `win_type` and `win_target` stay stable while a beat waits for `mem_done`.
- R11: A rejected request responds in the cycle after acceptance. An accepted request raises `mem_valid` two cycles after acceptance and responds in the cycle after `mem_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, all ones on error |
| rsp_err | output | 1 | Rejected or aborted |
| mem_valid | output | 1 | Downstream beat outstanding |
| mem_write | output | 1 | Beat direction |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Beat write data |
| mem_done | input | 1 | Beat completes this edge |
| mem_abort | input | 1 | Beat aborted (valid with mem_done) |
| mem_rdata | input | 32 | Beat read data |
| win_type | output | 3 | Window access type code (4 or 5) |
| win_target | output | 32 | Window target identifier |

## Verification
Suppose the latched request or the decode is wrong. The problem shows at the next downstream beat, two cycles after acceptance, as a bad address, type code or target word. It can also show one cycle after acceptance, as a missing rejection or an unexpected beat.

A stale or corrupted window shows as a target that does not match the last accepted off-bus-0 request. The bench also watches for window changes on bus-0 and rejected requests. It watches for changes during stalled beats as well.

An error-path fault shows in the response cycle as a read that is not all ones, or as a missing `rsp_err`.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    localparam logic [2:0] XT_TYPE0 = 3'd4;
    localparam logic [2:0] XT_TYPE1 = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ISSUE,
        ST_RESP
    } xl_state_e;
endpackage

// File: rtl/cfg_xlate_decode.sv
module cfg_xlate_decode
    import cfg_xlate_pkg::*;
#(
    parameter int          BUS_W        = 8,
    parameter int          DEV_W        = 5,
    parameter int          FN_W         = 3,
    parameter int          OFF_W        = 12,
    parameter int          ADDR_W       = 32,
    parameter int          BUS0_MAX_DEV = 1,
    parameter int          BUS1_MAX_DEV = 0,
    parameter logic [31:0] LOCAL_BASE   = 32'h01FF_C000,
    parameter logic [31:0] WIN_BASE     = 32'h01F0_0000
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    output logic              ok,
    output logic              remote,
    output logic [2:0]        typ,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] addr
);
    localparam int TGT_SH = ADDR_W - BUS_W - DEV_W - FN_W;

    logic [OFF_W-1:0] off_al;

    always_comb begin
        off_al = {off[OFF_W-1:2], 2'b00};
        remote = (bus != '0);
        if (bus == BUS_W'(0))
            ok = (int'(dev) <= BUS0_MAX_DEV);
        else if (bus == BUS_W'(1))
            ok = (int'(dev) <= BUS1_MAX_DEV);
        else
            ok = 1'b1;
        typ    = (bus < BUS_W'(2)) ? XT_TYPE0 : XT_TYPE1;
        target = {bus, dev, fn, {TGT_SH{1'b0}}};
        addr   = (remote ? WIN_BASE[ADDR_W-1:0] : LOCAL_BASE[ADDR_W-1:0])
                 + ADDR_W'(off_al);
    end
endmodule

// File: rtl/cfg_xlate_window.sv
module cfg_xlate_window
    import cfg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              ld_tgt,
    input  logic [2:0]        typ_in,
    input  logic [ADDR_W-1:0] tgt_in,
    output logic [2:0]        typ,
    output logic [ADDR_W-1:0] tgt
);
    typedef struct packed {
        logic [2:0]        typ;
        logic [ADDR_W-1:0] tgt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (ld) begin
            win_d.typ = typ_in;
            if (ld_tgt)
                win_d.tgt = tgt_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '{typ: XT_TYPE0, tgt: '0};
        else
            win_q <= win_d;
    end

    assign typ = win_q.typ;
    assign tgt = win_q.tgt;

    // R4
    type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (typ == XT_TYPE0) || (typ == XT_TYPE1));
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          BUS_W        = 8,
    parameter int          DEV_W        = 5,
    parameter int          FN_W         = 3,
    parameter int          OFF_W        = 12,
    parameter int          DATA_W       = 32,
    parameter int          ADDR_W       = 32,
    parameter int          BUS0_MAX_DEV = 1,
    parameter int          BUS1_MAX_DEV = 0,
    parameter logic [31:0] LOCAL_BASE   = 32'h01FF_C000,
    parameter logic [31:0] WIN_BASE     = 32'h01F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic              mem_abort,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [2:0]        win_type,
    output logic [ADDR_W-1:0] win_target
);
    typedef struct packed {
        xl_state_e         st;
        logic              wr;
        logic              remote;
        logic [2:0]        typ;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              dec_ok, dec_remote, win_ld;
    logic [2:0]        dec_typ;
    logic [ADDR_W-1:0] dec_tgt, dec_addr;

    cfg_xlate_decode #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
        .ADDR_W(ADDR_W), .BUS0_MAX_DEV(BUS0_MAX_DEV),
        .BUS1_MAX_DEV(BUS1_MAX_DEV), .LOCAL_BASE(LOCAL_BASE),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
        .ok(dec_ok), .remote(dec_remote), .typ(dec_typ),
        .target(dec_tgt), .addr(dec_addr)
    );

    cfg_xlate_window #(.ADDR_W(ADDR_W)) u_win (
        .clk(clk), .rst_n(rst_n), .ld(win_ld), .ld_tgt(ctl_q.remote),
        .typ_in(ctl_q.typ), .tgt_in(ctl_q.tgt),
        .typ(win_type), .tgt(win_target)
    );

    always_comb begin
        ctl_d  = ctl_q;
        win_ld = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.wr     = req_write;
                    ctl_d.remote = dec_remote;
                    ctl_d.typ    = dec_typ;
                    ctl_d.tgt    = dec_tgt;
                    ctl_d.addr   = dec_addr;
                    ctl_d.wdata  = req_wdata;
                    if (dec_ok) begin
                        ctl_d.st = ST_SETUP;
                    end else begin
                        ctl_d.st    = ST_RESP;
                        ctl_d.err   = 1'b1;
                        ctl_d.rdata = '1;
                    end
                end
            end
            ST_SETUP: begin
                win_ld   = 1'b1;
                ctl_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mem_done) begin
                    ctl_d.st    = ST_RESP;
                    ctl_d.err   = mem_abort;
                    ctl_d.rdata = (mem_abort || ctl_q.wr) ? '1 : mem_rdata;
                end
            end
            ST_RESP: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '{st: ST_IDLE, rdata: '1, default: '0};
        else
            ctl_q <= ctl_d;
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign mem_valid = (ctl_q.st == ST_ISSUE);
    assign rsp_valid = (ctl_q.st == ST_RESP);
    assign mem_write = ctl_q.wr;
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = ctl_q.wdata;
    assign rsp_rdata = ctl_q.rdata;
    assign rsp_err   = ctl_q.err;

    // R10
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || rsp_valid) |-> !req_ready);

    // R10
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_done) |=> ($stable(win_type) && $stable(win_target)));

    // R7
    dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R8
    abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_done && mem_abort && !mem_write)
            |=> (rsp_valid && rsp_err && (rsp_rdata == '1)));

    // R2
    reject_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !dec_ok) |=> (rsp_valid && rsp_err));

    // R11
    issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && dec_ok) |=> !mem_valid ##1 mem_valid);
endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, mem_valid, mem_write;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata, win_target;
    logic        mem_done = 1'b0, mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  win_type;

    int tests = 0, fails = 0;
    logic [2:0]  exp_type = 3'd4;
    logic [31:0] exp_tgt = '0;

    always #2.5 clk = ~clk;

    cfg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev),
        .req_fn(req_fn), .req_off(req_off), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_abort(mem_abort),
        .mem_rdata(mem_rdata), .win_type(win_type), .win_target(win_target)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int bus, input int dev,
                          input int fn, input int off, input bit abort,
                          input int lag);
        bit          valid, seen;
        int          wait_n, stall;
        logic [31:0] exp_addr, exp_rd, wd, hold_tgt;
        logic [2:0]  hold_typ;
        valid = !((bus == 0 && dev > 1) || (bus == 1 && dev > 0));
        exp_addr = ((bus == 0) ? 32'h01FFC000 : 32'h01F00000) + (off & 32'hFFC);
        wd = 32'hC0DE0000 ^ (bus << 12) ^ (dev << 4) ^ off;
        exp_rd = 32'h5A5A0000 ^ ~exp_addr;
        hold_typ = win_type;
        hold_tgt = win_target;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev);
        req_fn = 3'(fn); req_off = 12'(off); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        seen = 1'b0;
        wait_n = 0;
        while (!rsp_valid && wait_n < 20) begin
            chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 32'd0);
            if (mem_valid && !seen) begin
                seen = 1'b1;
                chk(wait_n == 1, "R11 issue latency", 32'(wait_n), 32'd1);
                chk(mem_addr == exp_addr, "R5/R6/R7 addr", mem_addr, exp_addr);
                chk(mem_write == wr, "R9 write dir", 32'(mem_write), 32'(wr));
                if (wr) chk(mem_wdata == wd, "R9 wdata", mem_wdata, wd);
                exp_type = (bus < 2) ? 3'd4 : 3'd5;
                if (bus != 0)
                    exp_tgt = (32'(bus) << 24) | (32'(dev) << 19) | (32'(fn) << 16);
                chk(win_type == exp_type, "R4 type", 32'(win_type), 32'(exp_type));
                chk(win_target == exp_tgt, "R5/R6 target", win_target, exp_tgt);
                for (stall = 0; stall < lag; stall++) begin
                    @(negedge clk);
                    chk(mem_valid && win_type == exp_type && win_target == exp_tgt,
                        "R10 window stable", win_target, exp_tgt);
                end
                mem_done = 1'b1; mem_abort = abort; mem_rdata = exp_rd ^ 32'h5A5A0000 ^ 32'h5A5A0000;
                mem_rdata = 32'h5A5A0000 ^ ~mem_addr;
                @(posedge clk);
                @(negedge clk);
                mem_done = 1'b0; mem_abort = 1'b0;
                wait_n = wait_n + 1 + lag;
            end else if (!seen) begin
                @(negedge clk);
                wait_n++;
            end
        end
        chk(rsp_valid == 1'b1, "R11 response", 32'(rsp_valid), 32'd1);
        if (!valid) begin
            chk(wait_n == 0, "R11 reject latency", 32'(wait_n), 32'd0);
            chk(!seen, "R2 no beat", 32'(seen), 32'd0);
            chk(rsp_err == 1'b1, "R2 reject err", 32'(rsp_err), 32'd1);
            if (!wr) chk(rsp_rdata == 32'hFFFFFFFF, "R3 reject read", rsp_rdata, 32'hFFFFFFFF);
            chk(win_type == hold_typ && win_target == hold_tgt, "R3 window kept",
                win_target, hold_tgt);
        end else begin
            chk(seen, "R9 beat issued", 32'(seen), 32'd1);
            chk(rsp_err == abort, abort ? "R8 abort err" : "R9 no err",
                32'(rsp_err), 32'(abort));
            if (!wr) begin
                if (abort)
                    chk(rsp_rdata == 32'hFFFFFFFF, "R8 abort read", rsp_rdata, 32'hFFFFFFFF);
                else
                    chk(rsp_rdata == exp_rd, "R9 read data", rsp_rdata, exp_rd);
            end
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10 back idle", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_valid == 1'b0,
            "R1 reset handshake", {29'd0, req_ready, rsp_valid, mem_valid}, 32'h4);
        chk(win_type == 3'd4 && win_target == 32'd0, "R1 reset window",
            win_target, 32'd0);
        rst_n = 1'b1;
        foreach (req_bus[b]) begin end
        for (int bi = 0; bi < 6; bi++) begin
            int bus;
            bus = (bi < 4) ? bi : ((bi == 4) ? 17 : 255);
            for (int dev = 0; dev < 32; dev++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    access(wr[0], bus, dev, (dev ^ bus) & 7, (dev * 37 + bus * 5 + wr) & 12'hFFF,
                           ((dev + bus + wr) % 7) == 3, dev % 3);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule